// File: doc/BRIEF.md
# Set/Clear Peripheral Clock Gate Controller

This block holds the on/off request for up to 64 peripheral clocks and drives the matching gate-enable lines. Software never changes a gate by read-modify-write. Each bank of 32 clocks has a set strobe register and a clear strobe register. Writing a word to the set register switches on only the clocks whose data bit is 1. Writing a word to the clear register switches off only the clocks whose data bit is 1. All other clocks keep their state.

Each clock also has a status bit, which shows the gate state that has actually taken effect. After every change of a request the status bit follows it only after a fixed settling delay. Software polls the status register until it matches the request. The request and status registers of a bank can be read separately and can disagree while a change is in flight. A few clock positions are not implemented. They stay at 0 no matter what is written.

Top module: `clkgate_ctrl`

## Requirements
- R1: After reset, every implemented clock has its request bit and its status bit at 1. The reserved positions read 0, so bank 1 request and status read 0xFD7FFFF0 and bank 0 reads 0xFFFFFFFF.
- R2: Bank 0 sets requests by a write to address 0x24, and bank 1 by a write to address 0x34. Each data bit at 1 sets the request of that clock. Clocks whose data bit is 0 keep their request.
- R3: Bank 0 clears requests by a write to address 0x28, and bank 1 by a write to address 0x38. Each data bit at 1 clears the request of that clock. Clocks whose data bit is 0 keep their request.
- R4: Clock n belongs to bank n/32 at bit n%32. The request words read at 0x2C (bank 0) and 0x3C (bank 1). The status words read at 0x30 (bank 0) and 0x40 (bank 1).
- R5: When a write changes a request bit at clock edge k, the status bit of that clock keeps its old value through edge k+3 and takes the new value at edge k+4.
- R6: A change to a request bit while its own status update is still pending restarts the 4-edge delay from the newest change. This holds even when the new change falls on the edge where the earlier update would have landed.
- R7: Clock IDs 32, 33, 34, 35, 55 and 57 are reserved. Their request bits, status bits and gate-enable lines are always 0, whatever is written.
- R8: Reads of the set and clear addresses return 0. Reads of any address outside the eight mapped ones also return 0.
- R9: Writes to the request and status addresses have no effect on any request or status bit.
- R10: Bit n of gate_en equals the current request bit of clock n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write enable for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, available in the same cycle |
| gate_en | output | 64 | One gate-enable line per clock ID |

## Verification
Two things can happen on the same edge. A write can change a clock's request exactly when that clock's earlier pending status update was due to land. Separately, one lane can finish settling while a write starts a change on another lane. The bench produces the first case by writing the opposite value to a bit on the fourth edge after its previous change. It produces the second case by chaining strobe writes to different bits on consecutive cycles, and random traffic supplies many more overlaps. The outcome is judged by reading the status word on every cycle against a per-clock countdown model in the bench. In that model a new change always wins over the update that was due.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    localparam int BANK_W      = 32;
    localparam int NUM_BANKS   = 2;
    localparam int NUM_CLK     = BANK_W * NUM_BANKS;
    localparam int ADDR_W      = 8;
    localparam int BANK_STRIDE = 16;
    localparam int BANK_IDX_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int STRIDE_SH   = $clog2(BANK_STRIDE);

    // register kind is selected by address bits [3:2] inside a bank window
    typedef enum logic [1:0] {
        ACC_SET  = 2'd0,
        ACC_CLR  = 2'd1,
        ACC_REQ  = 2'd2,
        ACC_STAT = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic                  hit;
        logic [BANK_IDX_W-1:0] bank;
        acc_kind_e             kind;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] addr,
                                             input logic [ADDR_W-1:0] base);
        reg_dec_t          d;
        logic [ADDR_W-1:0] off;
        off    = addr - base;
        d.kind = acc_kind_e'(off[3:2]);
        d.bank = off[STRIDE_SH +: BANK_IDX_W];
        d.hit  = (addr >= base) && (off[1:0] == 2'b00)
                 && ((off >> STRIDE_SH) < ADDR_W'(NUM_BANKS));
        return d;
    endfunction

endpackage

// File: rtl/clkgate_lane.sv
module clkgate_lane #(
    parameter int   SETTLE   = 4,
    parameter logic RESERVED = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic req_o,
    output logic stat_o
);
    localparam int CW = $clog2(SETTLE + 1);

    generate
        if (RESERVED) begin : g_tied
            logic unused_lane;
            assign unused_lane = ^{clk, rst, set_i, clr_i};
            assign req_o  = 1'b0;
            assign stat_o = 1'b0;
        end else begin : g_live
            logic          req_q, stat_q, req_nx;
            logic [CW-1:0] wait_q;

            always_comb begin
                req_nx = req_q;
                if (set_i)      req_nx = 1'b1;
                else if (clr_i) req_nx = 1'b0;
            end

            // a fresh change reloads the countdown; status lands when it expires
            always_ff @(posedge clk) begin
                if (rst) begin
                    req_q  <= 1'b1;
                    stat_q <= 1'b1;
                    wait_q <= '0;
                end else begin
                    req_q <= req_nx;
                    if (req_nx != req_q) begin
                        wait_q <= CW'(SETTLE);
                    end else if (wait_q != '0) begin
                        wait_q <= wait_q - 1'b1;
                        if (wait_q == CW'(1)) stat_q <= req_q;
                    end
                end
            end

            assign req_o  = req_q;
            assign stat_o = stat_q;
        end
    endgenerate

endmodule

// File: rtl/clkgate_bank.sv
module clkgate_bank
    import clkgate_pkg::*;
#(
    parameter int              SETTLE = 4,
    parameter logic [BANK_W-1:0] RSV  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_stb,
    input  logic              clr_stb,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] req,
    output logic [BANK_W-1:0] stat
);
    generate
        for (genvar i = 0; i < BANK_W; i++) begin : g_lane
            clkgate_lane #(
                .SETTLE  (SETTLE),
                .RESERVED(RSV[i])
            ) u_lane (
                .clk   (clk),
                .rst   (rst),
                .set_i (set_stb & wdata[i]),
                .clr_i (clr_stb & wdata[i]),
                .req_o (req[i]),
                .stat_o(stat[i])
            );
        end
    endgenerate

endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
    import clkgate_pkg::*;
#(
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h24,
    parameter int                 SETTLE    = 4,
    parameter logic [NUM_CLK-1:0] RSV_MASK  = 64'h0280_000F_0000_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [BANK_W-1:0]  reg_wdata,
    output logic [BANK_W-1:0]  reg_rdata,
    output logic [NUM_CLK-1:0] gate_en
);
    reg_dec_t                            dec;
    logic [NUM_BANKS-1:0][BANK_W-1:0]    req_bank, stat_bank;
    logic [NUM_CLK-1:0]                  req_vec, stat_vec;

    assign dec = decode_addr(reg_addr, BASE_ADDR);

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic sel;
            assign sel = reg_we && dec.hit && (dec.bank == BANK_IDX_W'(b));

            clkgate_bank #(
                .SETTLE(SETTLE),
                .RSV   (RSV_MASK[b*BANK_W +: BANK_W])
            ) u_bank (
                .clk    (clk),
                .rst    (rst),
                .set_stb(sel && (dec.kind == ACC_SET)),
                .clr_stb(sel && (dec.kind == ACC_CLR)),
                .wdata  (reg_wdata),
                .req    (req_bank[b]),
                .stat   (stat_bank[b])
            );

            assign req_vec [b*BANK_W +: BANK_W] = req_bank[b];
            assign stat_vec[b*BANK_W +: BANK_W] = stat_bank[b];
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        if (dec.hit) begin
            unique case (dec.kind)
                ACC_REQ:  reg_rdata = req_bank[dec.bank];
                ACC_STAT: reg_rdata = stat_bank[dec.bank];
                default:  reg_rdata = '0;
            endcase
        end
    end

    assign gate_en = req_vec;

endmodule

// File: rtl/clkgate_ctrl_chk.sv
module clkgate_ctrl_chk
    import clkgate_pkg::*;
#(
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h24,
    parameter logic [NUM_CLK-1:0] RSV_MASK  = 64'h0280_000F_0000_0000
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_we,
    input logic [BANK_W-1:0]  reg_wdata,
    input logic [BANK_W-1:0]  reg_rdata,
    input logic [NUM_CLK-1:0] gate_en,
    input logic [NUM_CLK-1:0] req_vec,
    input logic [NUM_CLK-1:0] stat_vec
);
    localparam logic [ADDR_W-1:0] SET0 = BASE_ADDR;
    localparam logic [ADDR_W-1:0] CLR0 = BASE_ADDR + 8'h04;

    // R2: a bank 0 set write leaves every written-1 bit requested
    p_set_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == SET0) |=>
            ((req_vec[BANK_W-1:0] & $past(reg_wdata)) == $past(reg_wdata)));

    // R3: a bank 0 clear write drops every written-1 bit
    p_clr_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == CLR0) |=>
            ((req_vec[BANK_W-1:0] & $past(reg_wdata)) == '0));

    // R5: a status bit only ever moves toward the present request
    p_stat_toward_req_r5: assert property (@(posedge clk) disable iff (rst)
        ((stat_vec ^ $past(stat_vec)) & (stat_vec ^ req_vec)) == '0);

    // R5/R6: request and status of one clock never switch on the same edge
    p_no_same_edge_r6: assert property (@(posedge clk) disable iff (rst)
        ((req_vec ^ $past(req_vec)) & (stat_vec ^ $past(stat_vec))) == '0);

    // R7: reserved gate lines stay low
    p_rsv_low_r7: assert property (@(posedge clk) disable iff (rst)
        ((gate_en | stat_vec) & RSV_MASK) == '0);

    // R8: strobe addresses read as zero
    p_strobe_read_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == SET0 || reg_addr == CLR0) |-> (reg_rdata == '0));

endmodule

bind clkgate_ctrl clkgate_ctrl_chk #(
    .BASE_ADDR(BASE_ADDR),
    .RSV_MASK (RSV_MASK)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .gate_en  (gate_en),
    .req_vec  (req_vec),
    .stat_vec (stat_vec)
);

// File: tb/test_clkgate_ctrl.sv
module test_clkgate_ctrl;
    localparam logic [63:0] RSV = 64'h0280_000F_0000_0000;
    localparam int          DLY = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] gate_en;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [63:0] m_req, m_stat;
    int          m_cnt [64];

    always #10 clk = ~clk;

    clkgate_ctrl i_clkgate_ctrl (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gate_en(gate_en)
    );

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycles=%0d expected < 100000", cyc);
            report();
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h2C:   return m_req[31:0];
            8'h30:   return m_stat[31:0];
            8'h3C:   return m_req[63:32];
            8'h40:   return m_stat[63:32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string auto_tag(input logic [7:0] a);
        case (a)
            8'h2C, 8'h3C: return "R2";
            8'h30, 8'h40: return "R5";
            default:      return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive, check pre-edge read and gates, step model after edge
    task automatic tick(input logic we, input logic [7:0] a, input logic [31:0] d,
                        input string tag);
        string t;
        logic [63:0] nreq;
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d;
        #1;
        t = (tag == "") ? auto_tag(a) : tag;
        if (!we) check(t, {32'h0, reg_rdata}, {32'h0, exp_rd(a)});
        check("R10", gate_en, m_req);
        @(posedge clk);
        nreq = m_req;
        if (we) begin
            case (a)
                8'h24: nreq[31:0]  = m_req[31:0]  | d;
                8'h28: nreq[31:0]  = m_req[31:0]  & ~d;
                8'h34: nreq[63:32] = m_req[63:32] | d;
                8'h38: nreq[63:32] = m_req[63:32] & ~d;
                default: ;
            endcase
        end
        nreq = nreq & ~RSV;
        for (int i = 0; i < 64; i++) begin
            if (nreq[i] != m_req[i]) m_cnt[i] = DLY;
            else if (m_cnt[i] != 0) begin
                if (m_cnt[i] == 1) m_stat[i] = m_req[i];
                m_cnt[i]--;
            end
        end
        m_req = nreq;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        tick(1'b0, a, 32'h0, tag);
    endtask

    logic [7:0] addr_pool [10] = '{8'h24, 8'h28, 8'h2C, 8'h30, 8'h34,
                                   8'h38, 8'h3C, 8'h40, 8'h00, 8'h44};

    initial begin
        void'($urandom(32'd1234));
        m_req  = ~RSV;
        m_stat = ~RSV;
        for (int i = 0; i < 64; i++) m_cnt[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h2C, "R1"); rd(8'h30, "R1"); rd(8'h3C, "R1"); rd(8'h40, "R1");
        check("R1", {32'h0, 32'hFD7F_FFF0}, {32'h0, exp_rd(8'h3C)});

        // R8 strobe and unmapped reads
        rd(8'h24, "R8"); rd(8'h38, "R8"); rd(8'h20, "R8"); rd(8'h50, "R8");

        // R3/R2 bank 0 masks
        tick(1'b1, 8'h28, 32'h0000_F0F0, "R3");
        rd(8'h2C, "R3");
        tick(1'b1, 8'h24, 32'h0000_0030, "R2");
        rd(8'h2C, "R2");

        // R4 id 36 lives in bank 1 bit 4
        tick(1'b1, 8'h38, 32'h0000_0010, "R4");
        rd(8'h3C, "R4");
        check("R4", {63'h0, gate_en[36]}, 64'h0);

        // R5 settle timing, status polled on every cycle
        tick(1'b1, 8'h28, 32'h0000_0001, "R5");
        repeat (6) rd(8'h30, "R5");

        // R6 revert on the very edge where the first update would land
        tick(1'b1, 8'h28, 32'h0000_0200, "R6");
        rd(8'h30, "R6"); rd(8'h30, "R6"); rd(8'h30, "R6");
        tick(1'b1, 8'h24, 32'h0000_0200, "R6");
        repeat (6) rd(8'h30, "R6");
        // R6 restart with a second change mid-wait, other lanes overlapping
        tick(1'b1, 8'h28, 32'h0000_0100, "R6");
        tick(1'b1, 8'h28, 32'h0000_0400, "R6");
        tick(1'b1, 8'h24, 32'h0000_0100, "R6");
        tick(1'b1, 8'h28, 32'h0000_0100, "R6");
        repeat (7) rd(8'h30, "R6");

        // R7 reserved positions
        tick(1'b1, 8'h38, 32'hFFFF_FFFF, "R7");
        tick(1'b1, 8'h34, 32'hFFFF_FFFF, "R7");
        rd(8'h3C, "R7");
        repeat (5) rd(8'h40, "R7");
        check("R7", gate_en & RSV, 64'h0);

        // R9 writes to readback registers are ignored
        tick(1'b1, 8'h2C, 32'h0000_0000, "R9");
        tick(1'b1, 8'h30, 32'h0000_0000, "R9");
        tick(1'b1, 8'h3C, 32'h0000_0000, "R9");
        tick(1'b1, 8'h40, 32'h0000_0000, "R9");
        rd(8'h2C, "R9"); rd(8'h30, "R9"); rd(8'h3C, "R9"); rd(8'h40, "R9");

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic        w;
            a = addr_pool[$urandom_range(0, 9)];
            w = ($urandom_range(0, 9) < 6);
            d = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
            tick(w, a, d, "");
        end
        repeat (6) rd(8'h40, "R5");
        report();
    end
endmodule